// File: doc/BRIEF.md
# Accumulating Multiply Register Slice

This block is the operand and writeback portion of a single-cycle 32-bit integer core. It takes an instruction word and decodes its register fields and opcode. It holds the architectural register file, hands the two source operands to an external ALU, and commits one result per clock. The ALU result and the load data come in as plain inputs. Instruction fetch, the arithmetic unit itself, data memory and control flow all sit outside the block.

On top of the standard write-producing opcodes, the slice executes one custom instruction from the custom-0 opcode space. That instruction reads its destination register as an accumulator and writes back `rd + rs1 * rs2` in the same cycle. To do this, the register file has a third combinational read port addressed by the destination field, and the writeback selector has a third source. Chains of accumulate instructions can therefore run back to back, one per clock. This serves dot-product style inner loops.

Top module: `mac_slice_top`

## Requirements
- R1: An instruction with opcode bits[6:0] = 7'b0001011, funct3 bits[14:12] = 3'b000 and funct7 bits[31:25] = 7'b0000001 raises `mac_en_o` and `reg_write_o` and sets `result_src_o` to 2'b10.
- R2: An instruction with opcode 7'b0001011 and any other funct3 or funct7 value is a no-op: `reg_write_o` and `mac_en_o` stay low and no register changes.
- R3: The accumulate result is the low 32 bits of `x[rd] + x[rs1] * x[rs2]` on two's-complement operands. It is written to `rd` on the next rising edge.
- R4: Register reads are combinational. `rs1_data_o` reads the register named by bits[19:15] and `rs2_data_o` reads the register named by bits[24:20]. The accumulator is read from the register named by bits[11:7].
- R5: Register 0 reads as zero on every read port, and any write to it has no effect.
- R6: `wb_data_o` follows `result_src_o`: 2'b00 selects `alu_result_i`, 2'b01 selects `load_data_i`, 2'b10 selects the accumulate result, and 2'b11 falls back to `alu_result_i`.
- R7: The following opcodes write `alu_result_i` with select 2'b00: 0110011 (register-register), 0010011 (register-immediate), 0110111, 0010111, 1101111 and 1100111. Opcode 0000011 (load) writes `load_data_i` with select 2'b01. All other opcodes, including 0100011 (store) and 1100011 (branch), write nothing and drive select 2'b00.
- R8: A write does not bypass to the read ports in the same cycle. Each chained accumulate sees the value committed on the previous edge. Instruction 0x0262828B (rd=x5, rs1=x5, rs2=x6), with x5=66 and x6=10, yields 726, 7986, 87846 and 966306 on four consecutive cycles.
- R9: While `rst_ni` is low, every register is cleared to zero, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; register writes on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word of the current cycle |
| alu_result_i | input | 32 | Result from the external ALU |
| load_data_i | input | 32 | Data returned by a load |
| rs1_data_o | output | 32 | First source operand |
| rs2_data_o | output | 32 | Second source operand |
| reg_write_o | output | 1 | A register commit happens at the next edge |
| mac_en_o | output | 1 | Current instruction is the accumulate instruction |
| result_src_o | output | 2 | Writeback source select |
| wb_data_o | output | 32 | Value that is written back |

## Verification
The hardest case to reach is an accumulate whose destination also appears as a source in the very cycle a write lands. This is where a hidden bypass or a stale read would show up. The stimulus builds it with the chained accumulate vector, then runs a long random mix. That mix confines the register fields to x0 to x7, so destination and source registers collide often and x0 comes up as a target. A behavioural model tracks every register and checks the operands and writeback value on each clock. An asynchronous reset in the middle of the run, followed by readback, shows that the clear does not depend on an edge.

// File: rtl/mac_slice_pkg.sv
`timescale 1ns/1ps
package mac_slice_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned NREG = 32;
  localparam int unsigned RAW  = $clog2(NREG);

  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_CUST0  = 7'b0001011;
  localparam logic [6:0] F7_MAC     = 7'b0000001;
  localparam logic [2:0] F3_MAC     = 3'b000;

  typedef enum logic [1:0] {
    WB_ALU  = 2'b00,
    WB_LOAD = 2'b01,
    WB_MAC  = 2'b10
  } wb_sel_e;

  typedef struct packed {
    logic    reg_write;
    logic    mac_en;
    wb_sel_e src;
  } ctrl_t;
endpackage

// File: rtl/mac_slice_dec.sv
`timescale 1ns/1ps
module mac_slice_dec
  import mac_slice_pkg::*;
(
  input  logic [31:0]   instr_i,
  output ctrl_t         ctrl_o,
  output logic [RAW-1:0] rd_o,
  output logic [RAW-1:0] rs1_o,
  output logic [RAW-1:0] rs2_o
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;

  assign opc   = instr_i[6:0];
  assign f3    = instr_i[14:12];
  assign f7    = instr_i[31:25];
  assign rd_o  = instr_i[7 +: RAW];
  assign rs1_o = instr_i[15 +: RAW];
  assign rs2_o = instr_i[20 +: RAW];

  always_comb begin
    ctrl_o.reg_write = 1'b0;
    ctrl_o.mac_en    = 1'b0;
    ctrl_o.src       = WB_ALU;
    unique case (opc)
      OPC_OP, OPC_OPIMM, OPC_LUI, OPC_AUIPC, OPC_JAL, OPC_JALR:
        ctrl_o.reg_write = 1'b1;
      OPC_LOAD: begin
        ctrl_o.reg_write = 1'b1;
        ctrl_o.src       = WB_LOAD;
      end
      OPC_CUST0: begin
        // only the exact accumulate encoding acts; rest of custom-0 is a no-op
        if (f7 == F7_MAC && f3 == F3_MAC) begin
          ctrl_o.reg_write = 1'b1;
          ctrl_o.mac_en    = 1'b1;
          ctrl_o.src       = WB_MAC;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mac_slice_rf.sv
`timescale 1ns/1ps
module mac_slice_rf #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned NRD   = 3,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NRD-1:0][AW-1:0] raddr_i,
  output logic [NRD-1:0][DW-1:0] rdata_o,
  input  logic                   we_i,
  input  logic [AW-1:0]          waddr_i,
  input  logic [DW-1:0]          wdata_i
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i && waddr_i != '0) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // combinational reads, no same-cycle bypass
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = (raddr_i[g] == '0) ? '0 : mem_q[raddr_i[g]];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(we_i) && $past(waddr_i) != '0
      |-> mem_q[$past(waddr_i)] == $past(wdata_i)); // R3
endmodule

// File: rtl/mac_slice_mac.sv
`timescale 1ns/1ps
module mac_slice_mac #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o
);
  logic [DW-1:0] prod;
  // low half of a two's-complement product is sign-agnostic
  assign prod  = a_i * b_i;
  assign res_o = acc_i + prod;
endmodule

// File: rtl/mac_slice_wb.sv
`timescale 1ns/1ps
module mac_slice_wb #(
  parameter int unsigned DW = 32
) (
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] alu_i,
  input  logic [DW-1:0] load_i,
  input  logic [DW-1:0] mac_i,
  output logic [DW-1:0] data_o
);
  always_comb begin
    unique case (sel_i)
      2'b01:   data_o = load_i;
      2'b10:   data_o = mac_i;
      default: data_o = alu_i;
    endcase
  end
endmodule

// File: rtl/mac_slice_top.sv
`timescale 1ns/1ps
module mac_slice_top
  import mac_slice_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] instr_i,
  input  logic [31:0] alu_result_i,
  input  logic [31:0] load_data_i,
  output logic [31:0] rs1_data_o,
  output logic [31:0] rs2_data_o,
  output logic        reg_write_o,
  output logic        mac_en_o,
  output logic [1:0]  result_src_o,
  output logic [31:0] wb_data_o
);
  localparam int unsigned NRD = 3;

  ctrl_t                   ctrl;
  logic [RAW-1:0]          rd_a, rs1_a, rs2_a;
  logic [NRD-1:0][RAW-1:0] raddr;
  logic [NRD-1:0][XLEN-1:0] rdata;
  logic [XLEN-1:0]         mac_res;

  mac_slice_dec u_dec (
    .instr_i (instr_i),
    .ctrl_o  (ctrl),
    .rd_o    (rd_a),
    .rs1_o   (rs1_a),
    .rs2_o   (rs2_a)
  );

  assign raddr = {rd_a, rs2_a, rs1_a};

  mac_slice_rf #(.DW(XLEN), .DEPTH(NREG), .NRD(NRD)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raddr_i (raddr),
    .rdata_o (rdata),
    .we_i    (ctrl.reg_write),
    .waddr_i (rd_a),
    .wdata_i (wb_data_o)
  );

  mac_slice_mac #(.DW(XLEN)) u_mac (
    .acc_i (rdata[2]),
    .a_i   (rdata[0]),
    .b_i   (rdata[1]),
    .res_o (mac_res)
  );

  mac_slice_wb #(.DW(XLEN)) u_wb (
    .sel_i  (ctrl.src),
    .alu_i  (alu_result_i),
    .load_i (load_data_i),
    .mac_i  (mac_res),
    .data_o (wb_data_o)
  );

  assign rs1_data_o   = rdata[0];
  assign rs2_data_o   = rdata[1];
  assign reg_write_o  = ctrl.reg_write;
  assign mac_en_o     = ctrl.mac_en;
  assign result_src_o = ctrl.src;

  AST_MAC_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_en_o |-> reg_write_o && result_src_o == 2'b10); // R1
  AST_CUSTOM_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_i[6:0] == OPC_CUST0 && (instr_i[31:25] != F7_MAC || instr_i[14:12] != F3_MAC)
      |-> !reg_write_o && !mac_en_o); // R2
  AST_X0_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_i[19:15] == 5'd0 |-> rs1_data_o == '0); // R5
  AST_STORE_NOWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_i[6:0] == 7'b0100011 |-> !reg_write_o); // R7
  AST_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(reg_write_o) && $stable(instr_i) |-> $stable(rs1_data_o)); // R8
endmodule

// File: tb/mac_slice_top_tb_top.sv
`timescale 1ns/1ps
module mac_slice_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = 32'h0000_0023;
  logic [31:0] alu_r = '0;
  logic [31:0] ld_r  = '0;
  logic [31:0] rs1_d, rs2_d, wb_d;
  logic        rw, me;
  logic [1:0]  src;

  int errs = 0;
  int checks = 0;
  logic [31:0] ref_rf [32];
  logic [31:0] last_wb;
  logic [31:0] last_rs1;

  always #10 clk = ~clk; // 50 MHz

  mac_slice_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr),
    .alu_result_i(alu_r), .load_data_i(ld_r),
    .rs1_data_o(rs1_d), .rs2_data_o(rs2_d),
    .reg_write_o(rw), .mac_en_o(me), .result_src_o(src), .wb_data_o(wb_d)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [6:0] f7, input int rs2, input int rs1,
                                      input logic [2:0] f3, input int rd, input logic [6:0] op);
    return {f7, rs2[4:0], rs1[4:0], f3, rd[4:0], op};
  endfunction

  // one instruction per cycle; outputs compared mid-low-phase, model commits after
  task automatic step(input logic [31:0] ins, input logic [31:0] alu, input logic [31:0] ld);
    logic [6:0] op;
    logic e_we, e_mac;
    logic [1:0] e_src;
    logic [31:0] a, b, acc, e_wb;
    int rd;
    string t;
    @(negedge clk);
    instr = ins; alu_r = alu; ld_r = ld;
    #5;
    op = ins[6:0];
    rd = int'(ins[11:7]);
    a = ref_rf[ins[19:15]];
    b = ref_rf[ins[24:20]];
    acc = ref_rf[rd];
    e_we = 0; e_mac = 0; e_src = 2'b00;
    if (op == 7'b0001011) begin
      if (ins[31:25] == 7'b0000001 && ins[14:12] == 3'b000) begin
        e_we = 1; e_mac = 1; e_src = 2'b10;
      end
    end else if (op == 7'b0000011) begin
      e_we = 1; e_src = 2'b01;
    end else if (op inside {7'b0110011, 7'b0010011, 7'b0110111, 7'b0010111, 7'b1101111, 7'b1100111}) begin
      e_we = 1;
    end
    if (e_src == 2'b01) e_wb = ld;
    else if (e_src == 2'b10) e_wb = acc + 32'(longint'($signed(a)) * longint'($signed(b)));
    else e_wb = alu;
    t = (op == 7'b0001011) ? (e_mac ? "R1" : "R2") : "R7";
    chk("R4 rs1", rs1_d, a);
    chk("R4 rs2", rs2_d, b);
    chk({t, " we"}, {31'd0, rw}, {31'd0, e_we});
    chk({t, " mac"}, {31'd0, me}, {31'd0, e_mac});
    chk({t, " src"}, {30'd0, src}, {30'd0, e_src});
    chk(e_mac ? "R3 wb" : "R6 wb", wb_d, e_wb);
    last_wb = wb_d;
    last_rs1 = rs1_d;
    if (e_we && rd != 0) ref_rf[rd] = e_wb;
  endtask

  task automatic rd_reg(input int r);
    step(enc(7'd0, 0, r, 3'b010, 0, 7'b0100011), 32'hdead_beef, 32'hcafe_f00d);
  endtask

  logic done = 1'b0;
  initial begin
    #(20 * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) ref_rf[i] = '0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;

    // R9 reset state
    for (int r = 0; r < 32; r += 7) begin rd_reg(r); chk("R9 reset", last_rs1, 32'd0); end

    // R7 loads seed operands
    step(enc(7'd0, 0, 1, 3'b010, 5, 7'b0000011), 32'h1111, 32'd66);
    step(enc(7'd0, 0, 1, 3'b010, 6, 7'b0000011), 32'h2222, 32'd10);

    // R8 chained accumulate vector
    step(32'h0262828B, 32'h0, 32'h0); chk("R8 mac1", last_wb, 32'd726);
    step(32'h0262828B, 32'h0, 32'h0); chk("R8 mac2", last_wb, 32'd7986);
    step(32'h0262828B, 32'h0, 32'h0); chk("R8 mac3", last_wb, 32'd87846);
    step(32'h0262828B, 32'h0, 32'h0); chk("R8 mac4", last_wb, 32'd966306);
    rd_reg(5); chk("R8 x5 final", last_rs1, 32'd966306);

    // R2 custom-0 variants do nothing
    step(enc(7'b0000010, 6, 5, 3'b000, 5, 7'b0001011), 32'h77, 32'h88);
    step(enc(7'b0000001, 6, 5, 3'b001, 5, 7'b0001011), 32'h77, 32'h88);
    rd_reg(5); chk("R2 x5 unchanged", last_rs1, 32'd966306);

    // R5 writes to x0 are dropped
    step(enc(7'b0000001, 6, 5, 3'b000, 0, 7'b0001011), 32'h0, 32'h0);
    step(enc(7'd0, 0, 0, 3'b000, 0, 7'b0110011), 32'h1234_5678, 32'h0);
    rd_reg(0); chk("R5 x0 zero", last_rs1, 32'd0);

    // R3 signed operands and wraparound
    step(enc(7'd0, 0, 0, 3'b000, 7, 7'b0010011), 32'hFFFF_FFF9, 32'h0);  // -7
    step(enc(7'd0, 0, 0, 3'b000, 8, 7'b0110111), 32'h7FFF_FFFF, 32'h0);
    step(enc(7'd0, 0, 0, 3'b000, 9, 7'b0010111), 32'd100, 32'h0);
    step(enc(7'b0000001, 8, 7, 3'b000, 9, 7'b0001011), 32'h0, 32'h0);
    chk("R3 signed wrap", last_wb, 32'd100 + 32'h8000_0007);
    step(enc(7'b0000001, 7, 7, 3'b000, 7, 7'b0001011), 32'h0, 32'h0);
    chk("R3 neg sq", last_wb, 32'd42);

    // R6 load source vs ALU
    step(enc(7'd0, 0, 0, 3'b000, 10, 7'b0000011), 32'hAAAA_AAAA, 32'h5555_5555);
    chk("R6 load sel", last_wb, 32'h5555_5555);
    step(enc(7'd0, 0, 0, 3'b000, 11, 7'b1101111), 32'hAAAA_AAAA, 32'h5555_5555);
    chk("R6 alu sel", last_wb, 32'hAAAA_AAAA);

    // R7 branch/store leave regs alone
    step(enc(7'd0, 11, 10, 3'b000, 10, 7'b1100011), 32'h1, 32'h2);
    rd_reg(10); chk("R7 branch no write", last_rs1, 32'h5555_5555);

    // random mix with colliding register fields
    for (int n = 0; n < 600; n++) begin
      logic [6:0] ops [12];
      logic [6:0] op, f7;
      logic [2:0] f3;
      int k;
      ops = '{7'b0110011, 7'b0010011, 7'b0110111, 7'b0010111, 7'b1101111, 7'b1100111,
              7'b0000011, 7'b0001011, 7'b0001011, 7'b0001011, 7'b0100011, 7'b1100011};
      k = int'($urandom_range(11, 0));
      op = ops[k];
      f7 = ($urandom_range(3, 0) == 0) ? 7'($urandom) : 7'b0000001;
      f3 = ($urandom_range(3, 0) == 0) ? 3'($urandom) : 3'b000;
      step(enc(f7, int'($urandom_range(7, 0)), int'($urandom_range(7, 0)), f3,
               int'($urandom_range(7, 0)), op), $urandom, $urandom);
    end

    // R9 asynchronous clear mid-run
    @(negedge clk);
    instr = enc(7'd0, 6, 5, 3'b010, 0, 7'b0100011);
    rst_n = 1'b0;
    #2;
    chk("R9 async clear rs1", rs1_d, 32'd0);
    chk("R9 async clear rs2", rs2_d, 32'd0);
    for (int i = 0; i < 32; i++) ref_rf[i] = '0;
    @(posedge clk); #3 rst_n = 1'b1;
    rd_reg(9); chk("R9 x9 cleared", last_rs1, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule